// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit moves a data word left or right by a count from 0 to W-1 and produces the new carry, sign, zero and overflow flags. It performs logical shifts, which fill the vacated positions with zeros. It performs arithmetic shifts, where the right shift copies the sign bit downwards. It also performs plain rotates and rotates through carry, in which the carry flag joins the word as one more bit of the ring. In every mode the carry flag receives the last bit that leaves the word. The carry input is the current carry value of the surrounding status register. Arithmetic left shift gives the same word as logical left shift and raises the overflow flag when the sign bit changes at any single step of the shift.

Operations enter on a valid/ready port. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. The result and its flags appear on the next edge behind `out_valid`. The output register is a single stage. When the consumer holds `out_ready` low while `out_valid` is high, the output stays frozen and `in_ready` drops, so back-pressure reaches the producer at once. When `out_ready` is high, a new operation is taken in the same cycle that the previous result leaves, so one operation completes per cycle. The flag outputs keep their last values after a result has been consumed.

Top module: `srot_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data`, `out_carry`, `out_neg`, `out_zero` and `out_ovf` are all 0.
- R2: With op code 0 (left) or 1 (right) the word is shifted logically and the vacated bits are zeros. The carry becomes bit W-k of the input for a left shift and bit k-1 for a right shift.
- R3: Op code 3 shifts right arithmetically. The vacated high bits take the input sign bit and the carry becomes input bit k-1.
- R4: Op code 2 gives the same word and carry as op code 0. `out_ovf` is 1 exactly when the top k+1 input bits are not all equal. For every other op code `out_ovf` is 0.
- R5: Op code 4 rotates left and op code 5 rotates right by k. The carry becomes the bit that ends in bit 0 for a left rotate and in bit W-1 for a right rotate.
- R6: Op code 6 rotates left and op code 7 rotates right by k through a ring of W+1 bits made of the carry input above the word. The new carry is the top bit of the rotated ring.
- R7: A count of 0 returns the input word unchanged, returns the carry input as the carry, and gives `out_ovf` 0, in every op code.
- R8: `out_neg` equals bit W-1 of `out_data` and `out_zero` is 1 exactly when `out_data` is all zeros.
- R9: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operation taken at one edge appears at the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | W | Operand word |
| in_count | input | $clog2(W) | Shift or rotate count |
| in_op | input | 3 | Op code, 0..7 as in R2 to R6 |
| in_carry | input | 1 | Carry input from the status register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Shifted or rotated word |
| out_carry | output | 1 | New carry flag |
| out_neg | output | 1 | Sign of the result |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Sign changed during an arithmetic left shift |

## Verification
Two events can fall in the same clock edge: a result leaving the output register and a new operation entering it. A long random run keeps `in_valid` and `out_ready` high together, so each edge both drains a result and loads the next one. Each result is checked at the next falling edge against a step-by-step bench model, which shows that no result is dropped or repeated. A directed stall then holds `out_ready` low while a second operation waits. It checks that the first result stays frozen and that `in_ready` stays low, then releases the stall and checks that the waiting operation is taken on the same edge.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SHLA = 3'd2,
    OP_SHRA = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROLC = 3'd6,
    OP_RORC = 3'd7
  } op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic v;
  } flags_t;
endpackage

// File: rtl/srot_core.sv
module srot_core #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [CW-1:0] k,
  input  logic [2:0]    op,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          vout
);
  import srot_pkg::*;

  op_e op_q;
  assign op_q = op_e'(op);

  // Carry for left moves is bit W-k, for right moves bit k-1; count 0 keeps cin.
  logic [CW-1:0] idx_l, idx_r;
  logic          c_left, c_right, k_zero;
  assign k_zero  = (k == '0);
  assign idx_l   = CW'(W) - k;
  assign idx_r   = k - CW'(1);
  assign c_left  = k_zero ? cin : a[idx_l];
  assign c_right = k_zero ? cin : a[idx_r];

  // Candidate words
  logic [W-1:0] w_shl, w_shr, w_sra, w_rol, w_ror;
  logic [W:0]   ring, ring_l, ring_r;
  assign w_shl  = a << k;
  assign w_shr  = a >> k;
  assign w_sra  = $signed(a) >>> k;
  assign w_rol  = (a << k) | (a >> (W - 32'(k)));
  assign w_ror  = (a >> k) | (a << (W - 32'(k)));
  assign ring   = {cin, a};
  assign ring_l = (ring << k) | (ring >> (W + 1 - 32'(k)));
  assign ring_r = (ring >> k) | (ring << (W + 1 - 32'(k)));

  // Mask over the top k+1 bits for the sign-change detector
  logic [W-1:0] top_mask, top_bits;
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mask
      assign top_mask[gi] = (32'(gi) + 32'(k)) >= (W - 1);
    end
  endgenerate
  assign top_bits = a & top_mask;

  always_comb begin
    res  = w_shl;
    cout = c_left;
    vout = 1'b0;
    unique case (op_q)
      OP_SHL: begin
        res  = w_shl;
        cout = c_left;
      end
      OP_SHLA: begin
        res  = w_shl;
        cout = c_left;
        vout = !k_zero && (top_bits != '0) && (top_bits != top_mask);
      end
      OP_SHR: begin
        res  = w_shr;
        cout = c_right;
      end
      OP_SHRA: begin
        res  = w_sra;
        cout = c_right;
      end
      OP_ROL: begin
        res  = w_rol;
        cout = c_left;
      end
      OP_ROR: begin
        res  = w_ror;
        cout = c_right;
      end
      OP_ROLC: begin
        res  = ring_l[W-1:0];
        cout = ring_l[W];
      end
      OP_RORC: begin
        res  = ring_r[W-1:0];
        cout = ring_r[W];
      end
      default: begin
        res  = w_shl;
        cout = c_left;
      end
    endcase
  end
endmodule

// File: rtl/srot_flags.sv
module srot_flags #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]     res,
  input  logic             cin,
  input  logic             vin,
  output srot_pkg::flags_t flg
);
  assign flg.c = cin;
  assign flg.n = res[W-1];
  assign flg.z = (res == '0);
  assign flg.v = vin;
endmodule

// File: rtl/srot_outreg.sv
module srot_outreg #(
  parameter int unsigned W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             drain,
  input  logic [W-1:0]     d_in,
  input  srot_pkg::flags_t f_in,
  output logic             vld,
  output logic [W-1:0]     d_out,
  output srot_pkg::flags_t f_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      d_out <= '0;
      f_out <= '0;
    end else if (take) begin
      vld   <= 1'b1;
      d_out <= d_in;
      f_out <= f_in;
    end else if (drain) begin
      vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/srot_unit.sv
module srot_unit #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [CW-1:0] in_count,
  input  logic [2:0]    in_op,
  input  logic          in_carry,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_carry,
  output logic          out_neg,
  output logic          out_zero,
  output logic          out_ovf
);
  logic [W-1:0]     core_res;
  logic             core_c, core_v, take;
  srot_pkg::flags_t core_f, reg_f;

  srot_core #(.W(W)) u_core (
    .a(in_data), .k(in_count), .op(in_op), .cin(in_carry),
    .res(core_res), .cout(core_c), .vout(core_v)
  );

  srot_flags #(.W(W)) u_flags (
    .res(core_res), .cin(core_c), .vin(core_v), .flg(core_f)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  srot_outreg #(.W(W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .take(take), .drain(out_ready),
    .d_in(core_res), .f_in(core_f),
    .vld(out_valid), .d_out(out_data), .f_out(reg_f)
  );

  assign out_carry = reg_f.c;
  assign out_neg   = reg_f.n;
  assign out_zero  = reg_f.z;
  assign out_ovf   = reg_f.v;
endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic [CW-1:0] in_count,
  input logic [2:0]    in_op,
  input logic          in_carry,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          out_carry,
  input logic          out_neg,
  input logic          out_zero,
  input logic          out_ovf
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_carry) && $stable(out_ovf)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_count == '0 |=> out_data == $past(in_data) && out_carry == $past(in_carry) && !out_ovf); // R7
  AST_OVF_SHLA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op != 3'd2 |=> !out_ovf); // R4
  AST_FLAG_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_neg == out_data[W-1] && out_zero == (out_data == '0)); // R8
endmodule

bind srot_unit srot_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_count(in_count), .in_op(in_op), .in_carry(in_carry),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_carry(out_carry), .out_neg(out_neg), .out_zero(out_zero), .out_ovf(out_ovf)
);

// File: tb/srot_unit_test.sv
`timescale 1ns/1ps
module srot_unit_test;
  localparam int unsigned W  = 16;
  localparam int unsigned CW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_carry = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_data = '0;
  logic [CW-1:0] in_count = '0;
  logic [2:0] in_op = '0;
  logic in_ready, out_valid, out_carry, out_neg, out_zero, out_ovf;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  srot_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_count(in_count), .in_op(in_op), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_carry(out_carry), .out_neg(out_neg), .out_zero(out_zero), .out_ovf(out_ovf)
  );

  typedef struct packed {
    logic [W-1:0] d;
    logic c;
    logic v;
  } exp_t;

  // Step-by-step model: one bit position per step
  function automatic exp_t model(input logic [W-1:0] a, input int k, input int op, input logic cin);
    exp_t e;
    logic c, nc;
    logic [W-1:0] x;
    x = a; c = cin; e.v = 1'b0;
    for (int s = 0; s < k; s++) begin
      case (op)
        0, 2: begin c = x[W-1]; x = {x[W-2:0], 1'b0}; if (op == 2 && x[W-1] != c) e.v = 1'b1; end
        1:    begin c = x[0]; x = {1'b0, x[W-1:1]}; end
        3:    begin c = x[0]; x = {x[W-1], x[W-1:1]}; end
        4:    begin c = x[W-1]; x = {x[W-2:0], x[W-1]}; end
        5:    begin c = x[0]; x = {x[0], x[W-1:1]}; end
        6:    begin nc = x[W-1]; x = {x[W-2:0], c}; c = nc; end
        default: begin nc = x[0]; x = {c, x[W-1:1]}; c = nc; end
      endcase
    end
    e.d = x; e.c = c;
    return e;
  endfunction

  function automatic string tag_of(input int op, input int k);
    if (k == 0) return "R7";
    case (op)
      0, 1: return "R2";
      2:    return "R4";
      3:    return "R3";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input exp_t e);
    chk(tag, "valid", W'(out_valid), W'(1));
    chk(tag, "data", out_data, e.d);
    chk(tag, "carry", W'(out_carry), W'(e.c));
    chk("R4", "ovf", W'(out_ovf), W'(e.v));
    chk("R8", "neg", W'(out_neg), W'(e.d[W-1]));
    chk("R8", "zero", W'(out_zero), W'(e.d == '0));
  endtask

  task automatic drive(input logic [W-1:0] d, input int k, input int op, input logic c);
    in_data = d; in_count = CW'(k); in_op = 3'(op); in_carry = c; in_valid = 1'b1;
  endtask

  task automatic one(input logic [W-1:0] d, input int k, input int op, input logic c);
    @(negedge clk);
    drive(d, k, op, c);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(tag_of(op, k), model(d, k, op, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    exp_t pe, ea, eb;
    string pt;
    logic [W-1:0] d;
    int k, op;
    logic c;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid", W'(out_valid), '0);
    chk("R1", "data", out_data, '0);
    chk("R1", "flags", W'({out_carry, out_neg, out_zero, out_ovf}), '0);
    rst_n = 1'b1;

    // Directed corner cases
    one(16'hF00F, 2, 0, 1'b0);    // R2 left, carry second bit out
    one(16'h8001, 1, 1, 1'b0);    // R2 right
    one(16'h0001, 1, 1, 1'b1);    // R2 and R8 zero result
    one(16'h8F00, 3, 3, 1'b0);    // R3 sign fill
    one(16'h4000, 1, 2, 1'b0);    // R4 sign changes
    one(16'hF000, 3, 2, 1'b0);    // R4 no change across top 4 bits
    one(16'hF000, 4, 2, 1'b0);    // R4 change at fourth step
    one(16'h8001, 15, 4, 1'b0);   // R5 rotate left max count
    one(16'h0003, 1, 5, 1'b0);    // R5 rotate right
    one(16'h8000, 1, 6, 1'b1);    // R6 ring left
    one(16'h0001, 15, 7, 1'b0);   // R6 ring right max count
    for (int o = 0; o < 8; o++) one(16'hA5C3, 0, o, 1'(o & 1)); // R7 count zero

    // Back-to-back random run: drain and load on the same edge
    out_ready = 1'b1;
    pt = "";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i > 0) check_result(pt, pe);
      d = W'($urandom); k = int'($urandom % W); op = int'($urandom % 8); c = 1'($urandom);
      if (i % 37 == 0) d = '0;
      drive(d, k, op, c);
      pe = model(d, k, op, c); pt = tag_of(op, k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_result(pt, pe);

    // Stall: R9 hold and back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(16'h1234, 4, 5, 1'b0);
    ea = model(16'h1234, 4, 5, 1'b0);
    @(negedge clk);
    drive(16'h8421, 3, 7, 1'b1);
    eb = model(16'h8421, 3, 7, 1'b1);
    check_result("R9", ea);
    chk("R9", "in_ready stalled", W'(in_ready), '0);
    repeat (3) begin
      @(negedge clk);
      check_result("R9", ea);
      chk("R9", "in_ready stalled", W'(in_ready), '0);
    end
    out_ready = 1'b1;
    #0.1;
    chk("R9", "in_ready released", W'(in_ready), W'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R9", eb);
    @(negedge clk);
    chk("R9", "drained", W'(out_valid), '0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule